// File: doc/BRIEF.md
# Configuration Host Sequencer

This block sits on the host side of a programmable device's configuration port. On a command it lowers an active-low configuration request, and it waits for the device's active-low status line to answer before it raises the request again. It then streams bitstream words from a local source toward the device under a ready/valid handshake. It takes the device's configuration-done as the end of the stream and reports the device as configured only when initialization-done arrives. Every edge it puts on the request line is gated: the request changes level only while it equals the status line.

When the device drops ready, the block withdraws valid after a fixed lag of one to six cycles. A status line that pulses low during configuration is a recoverable error. The block keeps the request high until status returns, then lowers the request and retries, up to a bounded number of times. A status line that stays low past a timeout, or too many retries, ends in a sticky fatal state that asks for a power cycle. A blind mode, chosen with each command, skips the status handshake. In that mode the block issues a timed low pulse on the request and streams without watching status.

Top module: `cfg_host_seq`

## Requirements
- R1: During and after reset, cfg_req_n, busy, configured, err_recov, err_timeout, fatal_pwr_cycle, src_ready and dev_valid are all 0.
- R2: Outside blind mode, cfg_req_n falls only while dev_stat_n is 1 and rises only while dev_stat_n is 0.
- R3: A cmd_start accepted while idle or configured drives cfg_req_n to 0 and holds it at 0 until dev_stat_n is 0. It then drives cfg_req_n to 1. busy reads 1 from the cycle after acceptance.
- R4: After cfg_req_n is raised, src_ready and dev_valid stay 0 until dev_stat_n has been seen at 1.
- R5: When dev_ready falls, dev_valid falls exactly READY_LAG cycles later (READY_LAG between 1 and 6). It returns READY_LAG cycles after dev_ready rises. Words reach the device in source order, each exactly once, and only on cycles where dev_valid and dev_ready are both 1.
- R6: dev_cfg_done ends streaming (src_ready 0). configured rises only on the cycle after dev_init_done is sampled at 1 in the initialization wait, and busy then reads 0.
- R7: If dev_init_done does not arrive within INIT_WAIT_CYC cycles after streaming ends, err_timeout is set, busy falls and configured stays 0. A later cmd_start is accepted and clears err_timeout.
- R8: If dev_stat_n goes to 0 during streaming or the initialization wait, cfg_req_n stays 1 until dev_stat_n returns to 1. err_recov is then set and cfg_req_n is driven to 0 to restart the handshake.
- R9: If dev_stat_n stays 0 for more than STUCK_CYC cycles while the block waits for it to rise, fatal_pwr_cycle is set. It stays set until reset, and cmd_start has no effect while it is set.
- R10: After MAX_RETRY automatic retries in one run, the next recoverable error sets fatal_pwr_cycle instead of retrying.
- R11: A cmd_start with cmd_blind at 1 drives cfg_req_n to 0 for exactly PULSE_CYC cycles, whatever the level of dev_stat_n. It then drives cfg_req_n to 1 and streams, and dev_stat_n then causes neither an error nor a timeout.
- R12: cmd_start has no effect while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | 1 | Start or reconfigure command, one-cycle pulse |
| cmd_blind | input | 1 | With cmd_start: 1 selects the timed pulse mode that ignores status |
| dev_stat_n | input | 1 | Device status, active low |
| dev_cfg_done | input | 1 | Device reports the bitstream received |
| dev_init_done | input | 1 | Device reports entry into user mode |
| src_valid | input | 1 | Bitstream source has a word |
| src_data | input | DATA_W | Bitstream source word |
| src_ready | output | 1 | Word taken from the source this cycle |
| dev_ready | input | 1 | Device accepts stream words |
| dev_valid | output | 1 | Stream word valid toward the device |
| dev_data | output | DATA_W | Stream word toward the device |
| cfg_req_n | output | 1 | Configuration request, active low |
| busy | output | 1 | A configuration run is in progress |
| configured | output | 1 | Device reached user mode |
| err_recov | output | 1 | A recoverable error was seen in this run |
| err_timeout | output | 1 | Initialization-done did not arrive in time |
| fatal_pwr_cycle | output | 1 | Unrecoverable error, power cycle requested |

## Verification
Each input takes effect on the first clock edge after it is driven, and the status flags follow the state register with no further delay. A change of the request line lags the state that wants it by one more edge. dev_valid lags dev_ready by READY_LAG edges through the ready delay line. The timeouts fire STUCK_CYC+1 or INIT_WAIT_CYC+1 edges after their wait begins, and the blind pulse lasts PULSE_CYC cycles. The bench drives on falling edges and samples on later falling edges. It checks the lag of the ready path on both sides of the exact edge, and it samples each timeout a few cycles before and a few cycles after its due edge, so that an off-by-a-few counter is caught.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DROP,
    ST_RAISE,
    ST_PULSE,
    ST_STREAM,
    ST_ERR_LOW,
    ST_WAIT_INIT,
    ST_DONE,
    ST_FATAL
  } seq_state_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // saturating count, restarted whenever the owner changes phase
  assign cnt_en = clr || (cnt != {CNT_W{1'b1}});

  always_comb begin
    cnt_d = cnt;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/cfg_req_gate.sv
module cfg_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic bypass,
  input  logic stat_n,
  output logic req_n
);

  logic req_d;
  logic req_en;

  // a level change is let through only while request equals status
  assign req_en = bypass || (req_n == stat_n);

  always_comb begin
    req_d = req_n;
    if (req_en) req_d = want_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_n <= 1'b0;
    else        req_n <= req_d;
  end

  p_req_edge_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_n != $past(req_n)) && !$past(bypass)) |-> ($past(req_n) == $past(stat_n)))
    else $error("request edge while request differed from status");

endmodule

// File: rtl/cfg_stream_stage.sv
module cfg_stream_stage #(
  parameter int DATA_W    = 16,
  parameter int READY_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dev_ready,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_data
);

  logic [READY_LAG-1:0] rdy_pipe;
  logic                 rdy_late;
  logic                 full_q, full_d;
  logic [DATA_W-1:0]    word_d;
  logic                 load, xfer;

  // delayed copy of ready: withdraws valid a fixed number of cycles late
  for (genvar g = 0; g < READY_LAG; g++) begin : g_lag
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_pipe[0] <= 1'b0;
        else        rdy_pipe[0] <= dev_ready;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_pipe[g] <= 1'b0;
        else        rdy_pipe[g] <= rdy_pipe[g-1];
      end
    end
  end

  assign rdy_late  = rdy_pipe[READY_LAG-1];
  assign dev_valid = en && full_q && rdy_late;
  assign xfer      = dev_valid && dev_ready;
  assign src_ready = en && (!full_q || xfer);
  assign load      = src_valid && src_ready;

  always_comb begin
    full_d = full_q;
    if (!en)       full_d = 1'b0;
    else if (load) full_d = 1'b1;
    else if (xfer) full_d = 1'b0;
    word_d = load ? src_data : dev_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dev_data <= '0;
    else if (load) dev_data <= word_d;
  end

  // run length of ready held low, for the withdraw check
  logic [2:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (dev_ready)      low_run <= '0;
    else if (low_run != 3'd7) low_run <= low_run + 3'd1;
  end

  p_valid_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run >= 3'(READY_LAG)) |-> !dev_valid)
    else $error("valid not withdrawn after ready dropped");

  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (!dev_valid || $stable(dev_data)))
    else $error("unaccepted word changed");

endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq
  import cfg_host_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int STUCK_CYC     = 1000,
  parameter int INIT_WAIT_CYC = 100000,
  parameter int PULSE_CYC     = 100000000,
  parameter int MAX_RETRY     = 3,
  parameter int READY_LAG     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_blind,
  input  logic              dev_stat_n,
  input  logic              dev_cfg_done,
  input  logic              dev_init_done,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dev_ready,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_data,
  output logic              cfg_req_n,
  output logic              busy,
  output logic              configured,
  output logic              err_recov,
  output logic              err_timeout,
  output logic              fatal_pwr_cycle
);

  localparam int MAX_LIM = max_of3(STUCK_CYC, INIT_WAIT_CYC, PULSE_CYC);
  localparam int TMR_W   = $clog2(MAX_LIM + 2) + 1;
  localparam int RETRY_W = $clog2(MAX_RETRY + 2);
  localparam logic [TMR_W-1:0]   STUCK_L = TMR_W'(STUCK_CYC);
  localparam logic [TMR_W-1:0]   INIT_L  = TMR_W'(INIT_WAIT_CYC);
  localparam logic [TMR_W-1:0]   PULSE_L = TMR_W'(PULSE_CYC - 1);
  localparam logic [RETRY_W-1:0] RETRY_L = RETRY_W'(MAX_RETRY);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  seq_state_e         state_q, state_d;
  logic [RETRY_W-1:0] retry_q, retry_d;
  logic               recov_q, recov_d;
  logic               tmo_q, tmo_d;
  logic               blind_q, blind_d;
  logic               want_hi;
  logic               tmr_clr;
  logic [TMR_W-1:0]   tmr_cnt;
  logic               stream_en;

  cfg_wait_timer #(.CNT_W(TMR_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (tmr_clr),
    .cnt   (tmr_cnt)
  );

  cfg_req_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .want_hi (want_hi),
    .bypass  (blind_q),
    .stat_n  (dev_stat_n),
    .req_n   (cfg_req_n)
  );

  cfg_stream_stage #(.DATA_W(DATA_W), .READY_LAG(READY_LAG)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (stream_en),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .dev_ready (dev_ready),
    .dev_valid (dev_valid),
    .dev_data  (dev_data)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    retry_d = retry_q;
    recov_d = recov_q;
    tmo_d   = tmo_q;
    blind_d = blind_q;
    want_hi = cfg_req_n;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (cmd_start) begin
          retry_d = '0;
          recov_d = 1'b0;
          tmo_d   = 1'b0;
          blind_d = cmd_blind;
          state_d = cmd_blind ? ST_PULSE : ST_DROP;
        end
      end
      ST_DROP: begin
        want_hi = 1'b0;
        if (!cfg_req_n && !dev_stat_n) state_d = ST_RAISE;
      end
      ST_RAISE: begin
        want_hi = 1'b1;
        if (cfg_req_n && dev_stat_n)          state_d = ST_STREAM;
        else if (!dev_stat_n && tmr_cnt >= STUCK_L) state_d = ST_FATAL;
      end
      ST_PULSE: begin
        want_hi = 1'b0;
        if (tmr_cnt == PULSE_L) state_d = ST_STREAM;
      end
      ST_STREAM: begin
        want_hi = 1'b1;
        if (!blind_q && !dev_stat_n) state_d = ST_ERR_LOW;
        else if (dev_cfg_done)       state_d = ST_WAIT_INIT;
      end
      ST_ERR_LOW: begin
        want_hi = 1'b1;
        if (dev_stat_n) begin
          recov_d = 1'b1;
          if (retry_q == RETRY_L) begin
            state_d = ST_FATAL;
          end else begin
            retry_d = retry_q + 1'b1;
            state_d = ST_DROP;
          end
        end else if (tmr_cnt >= STUCK_L) begin
          state_d = ST_FATAL;
        end
      end
      ST_WAIT_INIT: begin
        want_hi = 1'b1;
        if (!blind_q && !dev_stat_n) begin
          state_d = ST_ERR_LOW;
        end else if (dev_init_done) begin
          state_d = ST_DONE;
        end else if (tmr_cnt >= INIT_L) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_FATAL: ;
      default: state_d = ST_FATAL;
    endcase
  end

  assign tmr_clr   = (state_d != state_q);
  assign stream_en = (state_q == ST_STREAM);

  // register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      retry_q <= '0;
      recov_q <= 1'b0;
      tmo_q   <= 1'b0;
      blind_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
      recov_q <= recov_d;
      tmo_q   <= tmo_d;
      blind_q <= blind_d;
    end
  end

  assign busy            = !(state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FATAL);
  assign configured      = (state_q == ST_DONE);
  assign err_recov       = recov_q;
  assign err_timeout     = tmo_q;
  assign fatal_pwr_cycle = (state_q == ST_FATAL);

  p_no_stream_before_status_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (src_ready && !blind_q) |-> $past(dev_stat_n))
    else $error("stream opened before status rose");

  p_cfgd_after_init_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(configured) |-> $past(dev_init_done))
    else $error("configured without initialization-done");

  p_timeout_releases_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(err_timeout) |-> (!busy && !configured))
    else $error("timeout left the block busy or configured");

  p_req_held_in_error_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_ERR_LOW) |-> cfg_req_n)
    else $error("request dropped while status was low");

  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    fatal_pwr_cycle |=> fatal_pwr_cycle)
    else $error("fatal flag cleared without reset");

  p_retry_bound_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (retry_q <= RETRY_L))
    else $error("retry count beyond limit");

endmodule

// File: tb/cfg_host_seq_tb_top.sv
module cfg_host_seq_tb_top;

  localparam int DATA_W  = 8;
  localparam int STUCK   = 20;
  localparam int INITW   = 30;
  localparam int PULSE   = 16;
  localparam int RETRIES = 2;
  localparam int LAG     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_blind = 1'b0, dev_stat_n = 1'b0;
  logic dev_cfg_done = 1'b0, dev_init_done = 1'b0, dev_ready = 1'b1;
  logic src_valid = 1'b1;
  logic [DATA_W-1:0] src_word;
  logic src_ready, dev_valid, cfg_req_n, busy, configured;
  logic err_recov, err_timeout, fatal_pwr_cycle;
  logic [DATA_W-1:0] dev_data;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int rx_cnt;
  logic [DATA_W-1:0] exp_word;
  logic mon_on = 1'b0;

  always #5 clk = ~clk;

  cfg_host_seq #(
    .DATA_W(DATA_W), .STUCK_CYC(STUCK), .INIT_WAIT_CYC(INITW),
    .PULSE_CYC(PULSE), .MAX_RETRY(RETRIES), .READY_LAG(LAG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_blind(cmd_blind),
    .dev_stat_n(dev_stat_n), .dev_cfg_done(dev_cfg_done), .dev_init_done(dev_init_done),
    .src_valid(src_valid), .src_data(src_word), .src_ready(src_ready),
    .dev_ready(dev_ready), .dev_valid(dev_valid), .dev_data(dev_data),
    .cfg_req_n(cfg_req_n), .busy(busy), .configured(configured),
    .err_recov(err_recov), .err_timeout(err_timeout), .fatal_pwr_cycle(fatal_pwr_cycle)
  );

  // bitstream source: an incrementing word count
  always @(posedge clk) begin
    if (!rst_n)         src_word <= '0;
    else if (src_ready) src_word <= src_word + 1'b1;
  end

  // device-side monitor for order and uniqueness (R5)
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_word <= '0;
      rx_cnt   <= 0;
    end else if (dev_valid && dev_ready) begin
      if (mon_on) begin
        mon_chk <= mon_chk + 1;
        if (dev_data !== exp_word) begin
          mon_fail <= mon_fail + 1;
          $display("FAIL R5 word order: actual %0d expected %0d", dev_data, exp_word);
        end
      end
      exp_word <= exp_word + 1'b1;
      rx_cnt   <= rx_cnt + 1;
    end
  end

  // [15] cmd [14] blind [13] stat_n [12] cfg_done [11] init_done [10:7] cycles
  // expected [6] req_n [5] busy [4] configured [3] recov [2] timeout [1] fatal [0] src_ready
  localparam int NROW = 19;
  localparam logic [15:0] VEC [NROW] = '{
    16'b1_0_0_0_0_0100_1_1_0_0_0_0_0, // R3 start, request raised, R4 no stream yet
    16'b0_0_1_0_0_0100_1_1_0_0_0_0_1, // R4 status high opens stream
    16'b0_0_1_1_0_0100_1_1_0_0_0_0_0, // R6 cfg_done ends stream
    16'b0_0_1_1_1_0011_1_0_1_0_0_0_0, // R6 init_done -> configured
    16'b1_0_1_0_0_0100_0_1_0_0_0_0_0, // R3 reconfigure drops request
    16'b0_0_0_0_0_0100_1_1_0_0_0_0_0, // R3 status low -> request raised
    16'b0_0_1_0_0_0100_1_1_0_0_0_0_1, // R4 streaming
    16'b1_0_1_0_0_0100_1_1_0_0_0_0_1, // R12 start ignored while busy
    16'b0_0_0_0_0_0100_1_1_0_0_0_0_0, // R8 status pulse low, request held
    16'b0_0_1_0_0_0100_0_1_0_1_0_0_0, // R8 recovered, request dropped
    16'b0_0_0_0_0_0100_1_1_0_1_0_0_0, // R8 retry raise
    16'b0_0_1_0_0_0100_1_1_0_1_0_0_1, // R8 retry streaming
    16'b0_0_0_0_0_0100_1_1_0_1_0_0_0, // R10 second error
    16'b0_0_1_0_0_0100_0_1_0_1_0_0_0, // R10 second retry
    16'b0_0_0_0_0_0100_1_1_0_1_0_0_0, // R10 raise
    16'b0_0_1_0_0_0100_1_1_0_1_0_0_1, // R10 streaming
    16'b0_0_0_0_0_0100_1_1_0_1_0_0_0, // R10 third error
    16'b0_0_1_0_0_0100_1_0_0_1_0_1_0, // R10 retry limit reached -> fatal
    16'b1_0_1_0_0_0100_1_0_0_1_0_1_0  // R9 fatal sticky, start ignored
  };
  localparam int ROW_TAG [NROW] = '{3,4,6,6,3,3,4,12,8,8,8,8,10,10,10,10,10,10,9};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    cmd_start = 1'b0; cmd_blind = 1'b0; dev_stat_n = 1'b0;
    dev_cfg_done = 1'b0; dev_init_done = 1'b0; dev_ready = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic pulse_start(input logic blind);
    cmd_start = 1'b1; cmd_blind = blind;
    cyc(1);
    cmd_start = 1'b0;
  endtask

  task automatic bring_to_stream;
    pulse_start(1'b0); cyc(3);
    dev_stat_n = 1'b1; cyc(6);
  endtask

  initial begin
    cyc(2);
    // R1 reset state, during and after reset
    chk("R1 flags in reset", {cfg_req_n, busy, configured, err_recov, err_timeout, fatal_pwr_cycle}, 0);
    do_reset();
    chk("R1 flags after reset", {cfg_req_n, busy, configured, err_recov, err_timeout, fatal_pwr_cycle}, 0);
    chk("R1 stream idle", {src_ready, dev_valid}, 0);

    // vector table
    for (int i = 0; i < NROW; i++) begin
      logic [15:0] v;
      logic [6:0]  obs;
      string       tag;
      v = VEC[i];
      cmd_start = v[15]; cmd_blind = v[14]; dev_stat_n = v[13];
      dev_cfg_done = v[12]; dev_init_done = v[11];
      cyc(1);
      cmd_start = 1'b0;
      cyc(int'(v[10:7]) - 1);
      obs = {cfg_req_n, busy, configured, err_recov, err_timeout, fatal_pwr_cycle, src_ready};
      tag = $sformatf("R%0d row %0d", ROW_TAG[i], i);
      chk(tag, int'(obs), int'(v[6:0]));
    end

    // R9 stuck-low timing in the error wait
    do_reset();
    bring_to_stream();
    dev_stat_n = 1'b0;
    cyc(5);
    chk("R8 request held while status low", cfg_req_n, 1);
    cyc(14);
    chk("R9 no fatal before timeout", fatal_pwr_cycle, 0);
    cyc(4);
    chk("R9 fatal after timeout", fatal_pwr_cycle, 1);
    chk("R9 busy clear when fatal", busy, 0);

    // R7 initialization timeout
    do_reset();
    bring_to_stream();
    dev_cfg_done = 1'b1;
    cyc(28);
    chk("R7 still waiting", busy, 1);
    cyc(7);
    chk("R7 timeout flag", {busy, configured, err_timeout}, 3'b001);
    dev_cfg_done = 1'b0;
    pulse_start(1'b0); cyc(3);
    chk("R7 new start accepted", {busy, err_timeout}, 2'b10);

    // R5 ready drop and return, order checked by the monitor
    do_reset();
    mon_on = 1'b1;
    bring_to_stream();
    chk("R5 stream running", dev_valid, 1);
    dev_ready = 1'b0;
    cyc(2);
    chk("R5 valid still up before lag", dev_valid, 1);
    cyc(1);
    chk("R5 valid withdrawn at lag", dev_valid, 0);
    cyc(3);
    chk("R5 valid stays low", dev_valid, 0);
    cyc(2);
    dev_ready = 1'b1;
    begin
      int rx0;
      rx0 = rx_cnt;
      cyc(2);
      chk("R5 valid not back before lag", dev_valid, 0);
      cyc(1);
      chk("R5 valid back at lag", dev_valid, 1);
      cyc(10);
      chk("R5 words flow after resume", int'(rx_cnt - rx0 >= 8), 1);
    end
    mon_on = 1'b0;

    // R11 blind pulse mode
    do_reset();
    bring_to_stream();
    dev_cfg_done = 1'b1; cyc(4);
    dev_init_done = 1'b1; cyc(3);
    dev_cfg_done = 1'b0; dev_init_done = 1'b0;
    chk("R6 configured before blind run", configured, 1);
    begin
      int lows;
      lows = 0;
      cmd_start = 1'b1; cmd_blind = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        cmd_start = 1'b0;
        if (!cfg_req_n) lows++;
      end
      chk("R11 pulse width", lows, PULSE);
    end
    chk("R11 streaming after pulse", {cfg_req_n, busy, src_ready}, 3'b111);
    dev_stat_n = 1'b0;
    cyc(25);
    chk("R11 status ignored", {cfg_req_n, busy, err_recov, fatal_pwr_cycle}, 4'b1100);
    dev_cfg_done = 1'b1; dev_init_done = 1'b1;
    cyc(4);
    chk("R11 blind run configures", configured, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + mon_chk + 1, n_fail + mon_fail);
    $finish;
  end

endmodule